// File: doc/BRIEF.md
# Coprocessor Control and Semaphore Registers

This block holds the control state of a small vector coprocessor behind a simple register port. The port has independent read and write enables that share one address. The block keeps a status word of eleven flags: halt, single-step, interrupt-on-break and eight general signal flags. Software never writes these flags directly. Each write to the status address carries a pair of command bits per flag, one that sets the flag and one that clears it, so several flags can be changed in one write without a read-modify-write. An interrupt request line is driven by a separate command pair in the same word; it is not part of the status word.

The block also holds a hardware semaphore. Reading it acquires it, and any write releases it. Two DMA length registers, one per transfer direction, are writable by software and reload a fixed value when the matching DMA completion pulse arrives. After each status write, the block pulses a run-check line for one cycle when the core must re-examine its run state.

Top module: `cop_ctrl_regs`

## Requirements
- R1: After reset, halt_o is 1, status_o is 0x0001, irq_o and run_check_o are 0, the semaphore reads 0 and both length registers read 0.
- R2: In a status write (address 0), flag k has its clear command at data bit 2k and its set command at bit 2k+1. The flag index k is 0 for halt, 1 for single-step, 2 for interrupt-on-break, and 3 to 10 for signals 0 to 7. Set alone makes the flag 1 and clear alone makes it 0, from the cycle after the write.
- R3: A flag whose set and clear bits are both 1, or both 0, keeps its value. Writes to any other address leave every flag unchanged.
- R4: The interrupt request irq_o is cleared by data bit 22 and set by bit 23 of a status write, with the same both-or-neither rule. It appears in no bit of status_o.
- R5: status_o and a status read return halt at bit 0, single-step at bit 5, interrupt-on-break at bit 6 and signal i at bit 7+i. All other bits are 0.
- R6: run_check_o is 1 in the cycle after a status write exactly when, after that write, irq_o is 1 or halt is 1. At all other times it is 0.
- R7: A semaphore read (address 1) returns the current value in bit 0. The semaphore is 1 after the read, whether it was 0 or 1 before.
- R8: Any write to the semaphore address clears it to 0, whatever the data. When a read and a write of the semaphore arrive in the same cycle, the read returns the old value and the semaphore ends at 0.
- R9: The read-length register (address 2) and the write-length register (address 3) store the low 12 data bits of a write and read back zero-extended. A completion pulse on dma_rd_done_i or dma_wr_done_i reloads only its own register with 0xff8, and the reload wins over a write to that register in the same cycle.
- R10: reg_rdata_o shows the addressed register in the same cycle that reg_re_i is 1, and is 0 while reg_re_i is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_re_i | input | 1 | Read enable |
| reg_we_i | input | 1 | Write enable |
| reg_addr_i | input | ADDR_W | Register address, shared by read and write |
| reg_wdata_i | input | DATA_W | Write data or status command word |
| reg_rdata_o | output | DATA_W | Read data, combinational |
| dma_rd_done_i | input | 1 | DMA read transfer completion pulse |
| dma_wr_done_i | input | 1 | DMA write transfer completion pulse |
| status_o | output | DATA_W | Packed status word |
| irq_o | output | 1 | Interrupt request |
| halt_o | output | 1 | Halt flag to the core |
| run_check_o | output | 1 | One-cycle pulse asking the core to re-examine its run state |

## Verification
The bench targets pairs in which both the set and the clear bit are asserted. A design that let one command take priority would change the flag in those cases instead of holding it. It also checks that the semaphore reads 1 after being acquired and reads 0 after a release by arbitrary data. A simultaneous read and write must leave the semaphore at 0; a design that let the read win would leave it locked. Reload pulses that coincide with a software write to a length register are exercised, as are pulses that must leave the other direction's register alone. The run-check pulse is checked after writes that leave halt set while changing nothing, because a design that looked only for changes would stay quiet there.

// File: rtl/cop_ctrl_pkg.sv
package cop_ctrl_pkg;
  localparam int SIG_N     = 8;
  localparam int FLAG_N    = 3 + SIG_N;
  localparam int FLG_HALT  = 0;
  localparam int FLG_SSTEP = 1;
  localparam int FLG_IBRK  = 2;
  localparam int FLG_SIG0  = 3;
  localparam int IRQ_CLR_BIT = 2 * FLAG_N;
  localparam int IRQ_SET_BIT = 2 * FLAG_N + 1;
  localparam int CMD_W       = 2 * FLAG_N + 2;
  localparam int ADR_STATUS = 0;
  localparam int ADR_SEMA   = 1;
  localparam int ADR_RDLEN  = 2;
  localparam int ADR_WRLEN  = 3;
  localparam int STAT_GAP   = 4;

  // bit position of flag k in the packed status word
  function automatic int stat_pos(input int k);
    return (k == FLG_HALT) ? 0 : k + STAT_GAP;
  endfunction

  localparam int STAT_W = stat_pos(FLAG_N - 1) + 1;
endpackage

// File: rtl/setclr_flag.sv
module setclr_flag #(
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_en_i,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o,
  output logic d_o
);
  logic q;

  always_comb begin
    d_o = q;
    if (wr_en_i && set_i && !clr_i) d_o = 1'b1;
    else if (wr_en_i && clr_i && !set_i) d_o = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= RST_VAL;
    else         q <= d_o;
  end

  assign q_o = q;
endmodule

// File: rtl/sema_reg.sv
module sema_reg (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rd_en_i,
  input  logic wr_en_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q_o <= 1'b0;
    else if (wr_en_i) q_o <= 1'b0;  // release beats acquire
    else if (rd_en_i) q_o <= 1'b1;
  end
endmodule

// File: rtl/dma_len_reg.sv
module dma_len_reg #(
  parameter int             LEN_W  = 12,
  parameter logic [LEN_W-1:0] RELOAD = 12'hff8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [LEN_W-1:0] wdata_i,
  input  logic             done_i,
  output logic [LEN_W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q_o <= '0;
    else if (done_i)  q_o <= RELOAD;  // completion beats software write
    else if (wr_en_i) q_o <= wdata_i;
  end
endmodule

// File: rtl/cop_ctrl_regs.sv
module cop_ctrl_regs
  import cop_ctrl_pkg::*;
#(
  parameter int               ADDR_W     = 2,
  parameter int               DATA_W     = 32,
  parameter int               LEN_W      = 12,
  parameter logic [LEN_W-1:0] LEN_RELOAD = 12'hff8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_re_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic              dma_rd_done_i,
  input  logic              dma_wr_done_i,
  output logic [DATA_W-1:0] status_o,
  output logic              irq_o,
  output logic              halt_o,
  output logic              run_check_o
);
  localparam int N_DIR = 2;

  logic st_we, sem_re, sem_we;
  assign st_we  = reg_we_i && (reg_addr_i == ADDR_W'(ADR_STATUS));
  assign sem_re = reg_re_i && (reg_addr_i == ADDR_W'(ADR_SEMA));
  assign sem_we = reg_we_i && (reg_addr_i == ADDR_W'(ADR_SEMA));

  logic unused_wdata_hi;
  assign unused_wdata_hi = ^reg_wdata_i[DATA_W-1:CMD_W];

  // status flags
  logic [FLAG_N-1:0] flag_q, flag_d;
  for (genvar k = 0; k < FLAG_N; k++) begin : g_flag
    setclr_flag #(.RST_VAL(k == FLG_HALT)) u_flag (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_en_i (st_we),
      .set_i   (reg_wdata_i[2*k+1]),
      .clr_i   (reg_wdata_i[2*k]),
      .q_o     (flag_q[k]),
      .d_o     (flag_d[k])
    );
  end

  // interrupt request
  logic irq_q, irq_d;
  setclr_flag #(.RST_VAL(1'b0)) u_irq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (st_we),
    .set_i   (reg_wdata_i[IRQ_SET_BIT]),
    .clr_i   (reg_wdata_i[IRQ_CLR_BIT]),
    .q_o     (irq_q),
    .d_o     (irq_d)
  );

  logic run_check_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_check_q <= 1'b0;
    else         run_check_q <= st_we && (irq_d || flag_d[FLG_HALT]);
  end

  // semaphore
  logic sema_q;
  sema_reg u_sema (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rd_en_i (sem_re),
    .wr_en_i (sem_we),
    .q_o     (sema_q)
  );

  // DMA length registers, index 0 = read direction, 1 = write direction
  logic [LEN_W-1:0] len_q [N_DIR];
  logic [N_DIR-1:0] len_done;
  assign len_done = {dma_wr_done_i, dma_rd_done_i};

  for (genvar d = 0; d < N_DIR; d++) begin : g_len
    dma_len_reg #(.LEN_W(LEN_W), .RELOAD(LEN_RELOAD)) u_len (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_en_i (reg_we_i && (reg_addr_i == ADDR_W'(ADR_RDLEN + d))),
      .wdata_i (reg_wdata_i[LEN_W-1:0]),
      .done_i  (len_done[d]),
      .q_o     (len_q[d])
    );
  end

  // status packing
  logic [DATA_W-1:0] status_w;
  always_comb begin
    status_w = '0;
    for (int k = 0; k < FLAG_N; k++) status_w[stat_pos(k)] = flag_q[k];
  end

  // read mux
  always_comb begin
    reg_rdata_o = '0;
    if (reg_re_i) begin
      case (reg_addr_i)
        ADDR_W'(ADR_STATUS): reg_rdata_o = status_w;
        ADDR_W'(ADR_SEMA):   reg_rdata_o = DATA_W'(sema_q);
        ADDR_W'(ADR_RDLEN):  reg_rdata_o = DATA_W'(len_q[0]);
        ADDR_W'(ADR_WRLEN):  reg_rdata_o = DATA_W'(len_q[1]);
        default:             reg_rdata_o = '0;
      endcase
    end
  end

  assign status_o    = status_w;
  assign irq_o       = irq_q;
  assign halt_o      = flag_q[FLG_HALT];
  assign run_check_o = run_check_q;
endmodule

// File: rtl/cop_ctrl_regs_chk.sv
module cop_ctrl_regs_chk
  import cop_ctrl_pkg::*;
#(
  parameter int               ADDR_W     = 2,
  parameter int               DATA_W     = 32,
  parameter int               LEN_W      = 12,
  parameter logic [LEN_W-1:0] LEN_RELOAD = 12'hff8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_re_i,
  input logic              reg_we_i,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic              halt_clr_i,
  input logic              halt_set_i,
  input logic              sig0_clr_i,
  input logic              sig0_set_i,
  input logic              irq_clr_i,
  input logic              irq_set_i,
  input logic              dma_rd_done_i,
  input logic [DATA_W-1:0] status_o,
  input logic              irq_o,
  input logic              halt_o,
  input logic              run_check_o,
  input logic              sema_q,
  input logic [LEN_W-1:0]  rd_len_q
);
  function automatic logic [DATA_W-1:0] stat_mask();
    logic [DATA_W-1:0] m = '0;
    for (int k = 0; k < FLAG_N; k++) m[stat_pos(k)] = 1'b1;
    return m;
  endfunction
  localparam logic [DATA_W-1:0] STAT_MASK = stat_mask();

  logic st_we, sem_re, sem_we;
  assign st_we  = reg_we_i && (reg_addr_i == ADDR_W'(ADR_STATUS));
  assign sem_re = reg_re_i && (reg_addr_i == ADDR_W'(ADR_SEMA));
  assign sem_we = reg_we_i && (reg_addr_i == ADDR_W'(ADR_SEMA));

  assert_halt_set_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_we && halt_set_i && !halt_clr_i |=> halt_o);
  assert_sig0_clr_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_we && sig0_clr_i && !sig0_set_i |=> !status_o[stat_pos(FLG_SIG0)]);
  assert_halt_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(st_we && (halt_set_i ^ halt_clr_i)) |=> $stable(halt_o));
  assert_irq_set_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_we && irq_set_i && !irq_clr_i |=> irq_o);
  assert_irq_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(st_we && (irq_set_i ^ irq_clr_i)) |=> $stable(irq_o));
  assert_unused_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o & ~STAT_MASK) == '0);
  assert_run_check_cause_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_check_o |-> (irq_o || halt_o));
  assert_run_check_quiet_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !st_we |=> !run_check_o);
  assert_sema_acquire_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sem_re && !sem_we |=> sema_q);
  assert_sema_release_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sem_we |=> !sema_q);
  assert_rd_len_reload_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_rd_done_i |=> rd_len_q == LEN_RELOAD);
endmodule

bind cop_ctrl_regs cop_ctrl_regs_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W), .LEN_RELOAD(LEN_RELOAD)
) chk_i (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .reg_re_i      (reg_re_i),
  .reg_we_i      (reg_we_i),
  .reg_addr_i    (reg_addr_i),
  .halt_clr_i    (reg_wdata_i[0]),
  .halt_set_i    (reg_wdata_i[1]),
  .sig0_clr_i    (reg_wdata_i[6]),
  .sig0_set_i    (reg_wdata_i[7]),
  .irq_clr_i     (reg_wdata_i[22]),
  .irq_set_i     (reg_wdata_i[23]),
  .dma_rd_done_i (dma_rd_done_i),
  .status_o      (status_o),
  .irq_o         (irq_o),
  .halt_o        (halt_o),
  .run_check_o   (run_check_o),
  .sema_q        (sema_q),
  .rd_len_q      (len_q[0])
);

// File: tb/cop_ctrl_regs_tb_top.sv
module cop_ctrl_regs_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 2;
  localparam int DATA_W = 32;
  localparam logic [1:0] A_ST = 2'd0, A_SEM = 2'd1, A_RDL = 2'd2, A_WRL = 2'd3;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic reg_re_i = 1'b0, reg_we_i = 1'b0;
  logic [ADDR_W-1:0] reg_addr_i = '0;
  logic [DATA_W-1:0] reg_wdata_i = '0;
  logic [DATA_W-1:0] reg_rdata_o, status_o;
  logic dma_rd_done_i = 1'b0, dma_wr_done_i = 1'b0;
  logic irq_o, halt_o, run_check_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  cop_ctrl_regs dut_i (
    .clk_i, .rst_ni, .reg_re_i, .reg_we_i, .reg_addr_i, .reg_wdata_i,
    .reg_rdata_o, .dma_rd_done_i, .dma_wr_done_i, .status_o, .irq_o,
    .halt_o, .run_check_o
  );

  typedef struct packed {
    logic [31:0] wdata;
    logic [31:0] exp_stat;
    logic        exp_irq;
    logic        exp_rc;
  } vec_t;

  // applied in order from the reset state
  localparam vec_t VECS [10] = '{
    '{32'h0000_0001, 32'h0000_0000, 1'b0, 1'b0},  // clear halt
    '{32'h0000_0088, 32'h0000_00A0, 1'b0, 1'b0},  // set sstep, sig0
    '{32'h0020_000C, 32'h0000_40A0, 1'b0, 1'b0},  // sstep both, set sig7
    '{32'h0080_0040, 32'h0000_4020, 1'b1, 1'b1},  // set irq, clear sig0
    '{32'h00C0_0020, 32'h0000_4060, 1'b1, 1'b1},  // irq both, set intr-break
    '{32'h0050_0014, 32'h0000_0000, 1'b0, 1'b0},  // clear irq, sstep, ibrk, sig7
    '{32'h002A_AA82, 32'h0000_7F81, 1'b0, 1'b1},  // set halt, all signals
    '{32'h0000_0000, 32'h0000_7F81, 1'b0, 1'b1},  // neither bit anywhere
    '{32'hFFFF_FFFF, 32'h0000_7F81, 1'b0, 1'b1},  // both bits everywhere
    '{32'h0015_5541, 32'h0000_0000, 1'b0, 1'b0}   // clear halt, all signals
  };

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0; reg_wdata_i = '0;
  endtask

  task automatic rd_check(input logic [1:0] a, input logic [31:0] exp, input string req);
    @(negedge clk_i);
    reg_re_i = 1'b1; reg_addr_i = a;
    #1 check(reg_rdata_o, exp, req);
    @(negedge clk_i);
    reg_re_i = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset state
    check(status_o, 32'h1, "R1 status");
    check(32'(halt_o), 32'h1, "R1 halt");
    check(32'(irq_o), 32'h0, "R1 irq");
    check(32'(run_check_o), 32'h0, "R1 run_check");
    // R10 no read enable -> zero
    reg_addr_i = A_ST;
    #1 check(reg_rdata_o, 32'h0, "R10 idle rdata");
    rd_check(A_RDL, 32'h0, "R1 rd_len");
    rd_check(A_WRL, 32'h0, "R1 wr_len");

    // R2 R3 R4 R5 R6 table walk
    for (int i = 0; i < 10; i++) begin
      wr(A_ST, VECS[i].wdata);
      check(status_o, VECS[i].exp_stat, $sformatf("R2/R3/R5 vec %0d status", i));
      check(32'(irq_o), 32'(VECS[i].exp_irq), $sformatf("R4 vec %0d irq", i));
      check(32'(run_check_o), 32'(VECS[i].exp_rc), $sformatf("R6 vec %0d run_check", i));
      check(32'(halt_o), 32'(VECS[i].exp_stat[0]), $sformatf("R2 vec %0d halt", i));
      rd_check(A_ST, VECS[i].exp_stat, $sformatf("R5 vec %0d status read", i));
      check(32'(run_check_o), 32'h0, $sformatf("R6 vec %0d pulse ends", i));
    end

    // R3 writes elsewhere leave flags alone
    wr(A_SEM, 32'h002A_AA82);
    check(status_o, 32'h0, "R3 foreign write");
    check(32'(run_check_o), 32'h0, "R6 foreign write");

    // R7 R8 semaphore
    rd_check(A_SEM, 32'h0, "R7 first read");
    rd_check(A_SEM, 32'h1, "R7 held");
    rd_check(A_SEM, 32'h1, "R7 held again");
    wr(A_SEM, 32'h0000_1234);
    rd_check(A_SEM, 32'h0, "R8 release");
    @(negedge clk_i);
    reg_re_i = 1'b1; reg_we_i = 1'b1; reg_addr_i = A_SEM; reg_wdata_i = 32'h1;
    #1 check(reg_rdata_o, 32'h1, "R8 same-cycle old value");
    @(negedge clk_i);
    reg_re_i = 1'b0; reg_we_i = 1'b0;
    rd_check(A_SEM, 32'h0, "R8 write wins");

    // R9 length registers
    wr(A_RDL, 32'h0000_0123);
    rd_check(A_RDL, 32'h123, "R9 rd_len write");
    @(negedge clk_i); dma_rd_done_i = 1'b1;
    @(negedge clk_i); dma_rd_done_i = 1'b0;
    rd_check(A_RDL, 32'hFF8, "R9 rd reload");
    rd_check(A_WRL, 32'h0, "R9 wr_len untouched");
    wr(A_WRL, 32'hFFFF_F00C);
    rd_check(A_WRL, 32'h00C, "R9 wr_len truncation");
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_addr_i = A_WRL; reg_wdata_i = 32'h040; dma_wr_done_i = 1'b1;
    @(negedge clk_i);
    reg_we_i = 1'b0; dma_wr_done_i = 1'b0;
    rd_check(A_WRL, 32'hFF8, "R9 reload beats write");
    rd_check(A_RDL, 32'hFF8, "R9 rd_len untouched");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule